// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the processor-facing half of an I2C master. A simple single-cycle read/write port reaches a set of word-aligned registers. Through them software loads bus commands into a small command queue, drains received bytes from a receive queue, programs the bus timing and selects which events raise the single interrupt line. The bus protocol engine sits on the other side. It pulls commands from the head of the command queue, pushes received bytes into the receive queue, reports NACK and arbitration-loss events, and tells the front end whether it is busy.

Both queues raise a "ready" status bit from a programmable fill threshold. Status bits are sticky and are cleared by writing ones. Clearing the enable bit in the control register empties both queues and holds the engine idle. The timing values and the status bits keep their contents while the core is disabled.

Top module: `i2cRegFront`

## Requirements
- R1: After reset every register reads 0. Byte offsets: 0x08 control (bits 5:0), 0x0C interrupt enable (bits 4:0), 0x20 SCL low count, 0x24 SCL high count, 0x28 SDA hold count (each 16 bits, read/write, driven on sclLow, sclHigh, sdaHold). Any unmapped offset reads 0.
- R2: While the core is enabled, a write to offset 0x00 queues busWdata[9:0] (bit 9 start, bit 8 stop, bits 7:0 byte). The oldest entry is presented on cmdData with cmdValid high. A cycle with cmdTake high removes it. Offset 0x18 reads the number of queued commands (0 to 4 by default).
- R3: A command write while the command queue holds 4 entries is ignored. The level and the queued entries are unchanged.
- R4: While the core is enabled, rxValid pushes rxByte into the receive queue. A read of offset 0x04 returns the oldest byte and removes it. Offset 0x1C reads the number of held bytes.
- R5: A byte that arrives while the receive queue is full is discarded and sets status bit 4 (RX overflow).
- R6: Reading offset 0x04 while the receive queue is empty returns 0 and leaves the level at 0.
- R7: Status bit 0 (TX ready) is set in every enabled cycle in which the command level is at most control[3:2].
- R8: Status bit 1 (RX ready) is set in every enabled cycle in which the receive level exceeds control[5:4]. A threshold of 0 therefore triggers at one byte.
- R9: While enabled, nackEvt sets status bit 2 and arbEvt sets status bit 3.
- R10: Status (offset 0x10) bits stay set until cleared by writing 1 to them. A bit whose set condition still holds in the cycle of the clear stays set.
- R11: irq is high exactly when some status bit and its enable bit at 0x0C are both 1.
- R12: While control bit 0 is 0, both queues are empty and coreEn is low. Command writes and received bytes are ignored, and no status bit is set. The timing registers and existing status bits keep their values.
- R13: Offset 0x14 bit 0 reads engBusy while enabled and 0 while disabled. fastMode follows control bit 1 and coreEn follows control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle busRe is high |
| irq | output | 1 | Interrupt request |
| cmdValid | output | 1 | Command queue holds an entry |
| cmdData | output | 10 | Oldest command: start, stop, byte |
| cmdTake | input | 1 | Engine consumes the oldest command |
| rxValid | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| nackEvt | input | 1 | Engine saw a NACK |
| arbEvt | input | 1 | Engine lost arbitration |
| engBusy | input | 1 | Engine is active |
| coreEn | output | 1 | Core enable to the engine |
| fastMode | output | 1 | Fast bus speed selected |
| sclLow | output | 16 | SCL low period count |
| sclHigh | output | 16 | SCL high period count |
| sdaHold | output | 16 | SDA hold count |

## Verification
A wrong queue pointer or level shows up at once in the level registers. It shows up one command later as a byte that is out of order on cmdData or on receive-data reads. The bench sweeps every threshold against every fill level for both ready bits, so an off-by-one in either comparison appears in the first status read after the fill. A sticky bit that is lost or a clear that does not work shows up in the next status read and on irq in the same cycle. A flush that is missed or incomplete shows up as a nonzero level in the first read after the disable.

// File: rtl/i2cRegFrontPkg.sv
package i2cRegFrontPkg;

  localparam int ADDR_W = 6;
  localparam int CMD_W  = 10;
  localparam int BYTE_W = 8;
  localparam int ISR_W  = 5;
  localparam int THR_W  = 2;
  localparam int CTRL_W = 2 + 2 * THR_W;

  localparam int BIT_TXRDY = 0;
  localparam int BIT_RXRDY = 1;
  localparam int BIT_NACK  = 2;
  localparam int BIT_ARB   = 3;
  localparam int BIT_RXOVF = 4;

  typedef enum logic [3:0] {
    REG_CMD    = 4'd0,
    REG_RXD    = 4'd1,
    REG_CTRL   = 4'd2,
    REG_IEN    = 4'd3,
    REG_ISR    = 4'd4,
    REG_STAT   = 4'd5,
    REG_CMDLVL = 4'd6,
    REG_RXLVL  = 4'd7,
    REG_SCLLO  = 4'd8,
    REG_SCLHI  = 4'd9,
    REG_HOLD   = 4'd10
  } regIdx_e;

  // Strobes from the register control to the datapath
  typedef struct packed {
    logic             cmdPush;
    logic             rxPop;
    logic             flush;
    logic [ISR_W-1:0] clrMask;
  } dpStrobe_t;

endpackage

// File: rtl/rfFifo.sv
module rfFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (level == LVL_W'(DEPTH));
  assign empty  = (level == '0);
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign rdata  = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

endmodule

// File: rtl/i2cRfDatapath.sv
module i2cRfDatapath
  import i2cRegFrontPkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [CMD_W-1:0]  cmdWdata,
  input  logic              cmdTake,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              nackEvt,
  input  logic              arbEvt,
  input  logic [THR_W-1:0]  txThr,
  input  logic [THR_W-1:0]  rxThr,
  input  logic [ISR_W-1:0]  ienReg,
  output logic              cmdValid,
  output logic [CMD_W-1:0]  cmdData,
  output logic [LVL_W-1:0]  cmdLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic [BYTE_W-1:0] rxHead,
  output logic [ISR_W-1:0]  isrReg,
  output logic              irq
);

  logic cmdFull, cmdEmpty, rxFull, rxEmpty, enabled;
  logic [BYTE_W-1:0] rxOut;
  logic [ISR_W-1:0]  setVec;

  assign enabled = !stb.flush;

  rfFifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) cmdQ (
    .clk(clk), .rstN(rstN), .flush(stb.flush),
    .push(stb.cmdPush), .pop(cmdTake), .wdata(cmdWdata),
    .rdata(cmdData), .level(cmdLevel), .full(cmdFull), .empty(cmdEmpty)
  );

  rfFifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) rxQ (
    .clk(clk), .rstN(rstN), .flush(stb.flush),
    .push(rxValid), .pop(stb.rxPop), .wdata(rxByte),
    .rdata(rxOut), .level(rxLevel), .full(rxFull), .empty(rxEmpty)
  );

  assign cmdValid = !cmdEmpty;
  assign rxHead   = rxEmpty ? '0 : rxOut;

  always_comb begin
    setVec            = '0;
    setVec[BIT_TXRDY] = enabled && (int'(cmdLevel) <= int'(txThr));
    setVec[BIT_RXRDY] = enabled && (int'(rxLevel) > int'(rxThr));
    setVec[BIT_NACK]  = enabled && nackEvt;
    setVec[BIT_ARB]   = enabled && arbEvt;
    setVec[BIT_RXOVF] = enabled && rxValid && rxFull;
  end

  // Sticky bits: a pending set outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) isrReg <= '0;
    else       isrReg <= (isrReg & ~stb.clrMask) | setVec;
  end

  assign irq = |(isrReg & ienReg);

endmodule

// File: rtl/i2cRfControl.sv
module i2cRfControl
  import i2cRegFrontPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TIM_W  = 16,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              engBusy,
  input  logic [LVL_W-1:0]  cmdLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [BYTE_W-1:0] rxHead,
  input  logic [ISR_W-1:0]  isrReg,
  output dpStrobe_t         stb,
  output logic [ISR_W-1:0]  ienReg,
  output logic              coreEn,
  output logic              fastMode,
  output logic [THR_W-1:0]  txThr,
  output logic [THR_W-1:0]  rxThr,
  output logic [TIM_W-1:0]  sclLow,
  output logic [TIM_W-1:0]  sclHigh,
  output logic [TIM_W-1:0]  sdaHold
);

  logic [CTRL_W-1:0] ctrlReg;
  regIdx_e wordIdx;
  logic [DATA_W-1:0] rdMux;

  assign wordIdx  = regIdx_e'(busAddr[ADDR_W-1:2]);
  assign coreEn   = ctrlReg[0];
  assign fastMode = ctrlReg[1];
  assign txThr    = ctrlReg[2 +: THR_W];
  assign rxThr    = ctrlReg[2 + THR_W +: THR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      ienReg  <= '0;
      sclLow  <= '0;
      sclHigh <= '0;
      sdaHold <= '0;
    end else if (busWe) begin
      case (wordIdx)
        REG_CTRL:  ctrlReg <= busWdata[CTRL_W-1:0];
        REG_IEN:   ienReg  <= busWdata[ISR_W-1:0];
        REG_SCLLO: sclLow  <= busWdata[TIM_W-1:0];
        REG_SCLHI: sclHigh <= busWdata[TIM_W-1:0];
        REG_HOLD:  sdaHold <= busWdata[TIM_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    stb.cmdPush = busWe && (wordIdx == REG_CMD) && coreEn;
    stb.rxPop   = busRe && (wordIdx == REG_RXD) && coreEn;
    stb.flush   = !coreEn;
    stb.clrMask = (busWe && (wordIdx == REG_ISR)) ? busWdata[ISR_W-1:0] : '0;
  end

  always_comb begin
    case (wordIdx)
      REG_RXD:    rdMux = DATA_W'(rxHead);
      REG_CTRL:   rdMux = DATA_W'(ctrlReg);
      REG_IEN:    rdMux = DATA_W'(ienReg);
      REG_ISR:    rdMux = DATA_W'(isrReg);
      REG_STAT:   rdMux = DATA_W'(engBusy && coreEn);
      REG_CMDLVL: rdMux = DATA_W'(cmdLevel);
      REG_RXLVL:  rdMux = DATA_W'(rxLevel);
      REG_SCLLO:  rdMux = DATA_W'(sclLow);
      REG_SCLHI:  rdMux = DATA_W'(sclHigh);
      REG_HOLD:   rdMux = DATA_W'(sdaHold);
      default:    rdMux = '0;
    endcase
  end

  assign busRdata = busRe ? rdMux : '0;

endmodule

// File: rtl/i2cRegFront.sv
module i2cRegFront
  import i2cRegFrontPkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter int TIM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [5:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              cmdValid,
  output logic [9:0]        cmdData,
  input  logic              cmdTake,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              nackEvt,
  input  logic              arbEvt,
  input  logic              engBusy,
  output logic              coreEn,
  output logic              fastMode,
  output logic [TIM_W-1:0]  sclLow,
  output logic [TIM_W-1:0]  sclHigh,
  output logic [TIM_W-1:0]  sdaHold
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  dpStrobe_t         stb;
  logic [LVL_W-1:0]  cmdLevel, rxLevel;
  logic [BYTE_W-1:0] rxHead;
  logic [ISR_W-1:0]  isrReg, ienReg;
  logic [THR_W-1:0]  txThr, rxThr;

  i2cRfControl #(.DATA_W(DATA_W), .TIM_W(TIM_W), .LVL_W(LVL_W)) ctl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .engBusy(engBusy),
    .cmdLevel(cmdLevel), .rxLevel(rxLevel), .rxHead(rxHead), .isrReg(isrReg),
    .stb(stb), .ienReg(ienReg), .coreEn(coreEn), .fastMode(fastMode),
    .txThr(txThr), .rxThr(rxThr), .sclLow(sclLow), .sclHigh(sclHigh),
    .sdaHold(sdaHold)
  );

  i2cRfDatapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdWdata(busWdata[CMD_W-1:0]),
    .cmdTake(cmdTake), .rxValid(rxValid), .rxByte(rxByte),
    .nackEvt(nackEvt), .arbEvt(arbEvt), .txThr(txThr), .rxThr(rxThr),
    .ienReg(ienReg), .cmdValid(cmdValid), .cmdData(cmdData),
    .cmdLevel(cmdLevel), .rxLevel(rxLevel), .rxHead(rxHead),
    .isrReg(isrReg), .irq(irq)
  );

endmodule

// File: rtl/i2cRegFrontChecker.sv
module i2cRegFrontChecker #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic              busRe,
  input logic [5:0]        busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              rxValid,
  input logic              cmdTake,
  input logic              coreEn,
  input logic [LVL_W-1:0]  cmdLevel,
  input logic [LVL_W-1:0]  rxLevel,
  input logic [4:0]        isrReg
);

  assert_cmd_full_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr[5:2] == 4'd0 && cmdLevel == LVL_W'(DEPTH) && !cmdTake && coreEn)
      |=> (cmdLevel == LVL_W'(DEPTH)));

  assert_rx_overflow_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (coreEn && rxValid && rxLevel == LVL_W'(DEPTH)) |=> isrReg[4]);

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr[5:2] == 4'd1 && rxLevel == '0) |-> (busRdata == '0));

  assert_sticky_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr[5:2] == 4'd4) |=> (($past(isrReg) & ~isrReg) == 5'd0));

  assert_disable_flush_R12: assert property (@(posedge clk) disable iff (!rstN)
    !coreEn |=> (cmdLevel == '0 && rxLevel == '0));

endmodule

bind i2cRegFront i2cRegFrontChecker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
  .busRdata(busRdata), .rxValid(rxValid), .cmdTake(cmdTake), .coreEn(coreEn),
  .cmdLevel(cmdLevel), .rxLevel(rxLevel), .isrReg(isrReg)
);

// File: tb/i2cRegFront_test.sv
`timescale 1ns/1ps
module i2cRegFront_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irq, cmdValid, coreEn, fastMode;
  logic [9:0] cmdData;
  logic cmdTake = 1'b0, rxValid = 1'b0, nackEvt = 1'b0, arbEvt = 1'b0, engBusy = 1'b0;
  logic [7:0] rxByte = '0;
  logic [15:0] sclLow, sclHigh, sdaHold;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] rv;
  logic [9:0] sent [6];

  always #2.5 clk = ~clk;

  i2cRegFront uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .cmdValid(cmdValid),
    .cmdData(cmdData), .cmdTake(cmdTake), .rxValid(rxValid), .rxByte(rxByte),
    .nackEvt(nackEvt), .arbEvt(arbEvt), .engBusy(engBusy), .coreEn(coreEn),
    .fastMode(fastMode), .sclLow(sclLow), .sclHigh(sclHigh), .sdaHold(sdaHold)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic pulseTake();
    @(negedge clk);
    cmdTake = 1'b1;
    @(negedge clk);
    cmdTake = 1'b0;
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values and unmapped offset
    check("R11 irq after reset", {31'd0, irq}, 32'd0);
    check("R2 cmdValid after reset", {31'd0, cmdValid}, 32'd0);
    for (int a = 2; a < 12; a++) begin
      if (a == 5) continue;
      rd(6'(a * 4), rv);
      check($sformatf("R1 reset word %0d", a), rv, 32'd0);
    end
    rd(6'h2C, rv); check("R1 unmapped read", rv, 32'd0);

    // R1/R13: timing registers
    wr(6'h20, 32'h1234); wr(6'h24, 32'hABCD); wr(6'h28, 32'h0042);
    rd(6'h20, rv); check("R1 scl low readback", rv, 32'h1234);
    rd(6'h24, rv); check("R1 scl high readback", rv, 32'hABCD);
    rd(6'h28, rv); check("R1 hold readback", rv, 32'h0042);
    check("R13 sclHigh port", {16'd0, sclHigh}, 32'hABCD);

    // R13/R7/R11: enable with fast mode
    wr(6'h08, 32'h3);
    check("R13 coreEn", {31'd0, coreEn}, 32'd1);
    check("R13 fastMode", {31'd0, fastMode}, 32'd1);
    rd(6'h08, rv); check("R1 control readback", rv, 32'h3);
    rd(6'h10, rv); check("R7 tx ready at empty", rv & 32'h1, 32'h1);
    check("R11 irq masked", {31'd0, irq}, 32'd0);
    wr(6'h0C, 32'h1);
    check("R11 irq enabled", {31'd0, irq}, 32'd1);
    wr(6'h0C, 32'h0);

    // R2/R3: command queue order and full
    for (int i = 0; i < 6; i++) begin
      sent[i] = 10'((i * 149 + 517) & 10'h3FF);
      wr(6'h00, {22'd0, sent[i]});
      rd(6'h18, rv);
      check($sformatf("R3 cmd level after write %0d", i), rv, (i < 4) ? 32'(i + 1) : 32'd4);
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check($sformatf("R2 cmdValid entry %0d", i), {31'd0, cmdValid}, 32'd1);
      check($sformatf("R2 cmdData entry %0d", i), {22'd0, cmdData}, {22'd0, sent[i]});
      pulseTake();
    end
    check("R2 cmdValid drained", {31'd0, cmdValid}, 32'd0);
    rd(6'h18, rv); check("R2 cmd level drained", rv, 32'd0);

    // R7: every TX threshold against every fill level
    for (int thr = 0; thr < 4; thr++) begin
      for (int lv = 0; lv <= 4; lv++) begin
        wr(6'h08, 32'(1 | (thr << 2)));
        for (int k = 0; k < lv; k++) wr(6'h00, 32'(k));
        wr(6'h10, 32'h1F);
        rd(6'h10, rv);
        check($sformatf("R7 thr %0d level %0d", thr, lv), rv & 32'h1, (lv <= thr) ? 32'h1 : 32'h0);
        wr(6'h08, 32'h0);
      end
    end

    // R8/R4: every RX threshold against every fill level
    for (int thr = 0; thr < 4; thr++) begin
      for (int lv = 0; lv <= 4; lv++) begin
        wr(6'h08, 32'(1 | (thr << 4)));
        for (int k = 0; k < lv; k++) pushRx(8'(k));
        wr(6'h10, 32'h1F);
        rd(6'h10, rv);
        check($sformatf("R8 thr %0d level %0d", thr, lv), rv & 32'h2, (lv > thr) ? 32'h2 : 32'h0);
        rd(6'h1C, rv);
        check($sformatf("R4 rx level %0d", lv), rv, 32'(lv));
        wr(6'h08, 32'h0);
      end
    end

    // R5/R4/R6: overflow, order, empty read
    wr(6'h08, 32'h1);
    wr(6'h10, 32'h1F);
    for (int i = 0; i < 5; i++) pushRx(8'(8'hA0 + i));
    rd(6'h1C, rv); check("R5 rx level full", rv, 32'd4);
    rd(6'h10, rv); check("R5 overflow bit", rv & 32'h10, 32'h10);
    for (int i = 0; i < 4; i++) begin
      rd(6'h04, rv); check($sformatf("R4 rx byte %0d", i), rv, 32'(8'hA0 + i));
    end
    rd(6'h04, rv); check("R6 empty read value", rv, 32'd0);
    rd(6'h1C, rv); check("R6 empty read level", rv, 32'd0);

    // R9/R10/R11: events, sticky clear, irq gating
    wr(6'h10, 32'h1F);
    @(negedge clk); nackEvt = 1'b1; @(negedge clk); nackEvt = 1'b0;
    rd(6'h10, rv); check("R9 nack bit", rv & 32'h4, 32'h4);
    wr(6'h0C, 32'h4);
    check("R11 irq on nack", {31'd0, irq}, 32'd1);
    wr(6'h10, 32'h4);
    rd(6'h10, rv); check("R10 nack cleared", rv & 32'h4, 32'h0);
    check("R11 irq after clear", {31'd0, irq}, 32'd0);
    @(negedge clk); arbEvt = 1'b1; @(negedge clk); arbEvt = 1'b0;
    repeat (3) @(negedge clk);
    rd(6'h10, rv); check("R9 arb bit sticky", rv & 32'h8, 32'h8);
    wr(6'h10, 32'h1);
    rd(6'h10, rv); check("R10 tx ready survives clear", rv & 32'h1, 32'h1);

    // R13: busy
    engBusy = 1'b1;
    rd(6'h14, rv); check("R13 busy enabled", rv, 32'd1);

    // R12: soft disable
    wr(6'h00, 32'h55); wr(6'h00, 32'h66);
    pushRx(8'h11); pushRx(8'h22);
    wr(6'h08, 32'h0);
    check("R12 coreEn low", {31'd0, coreEn}, 32'd0);
    rd(6'h14, rv); check("R13 busy hidden when disabled", rv, 32'd0);
    rd(6'h18, rv); check("R12 cmd flushed", rv, 32'd0);
    rd(6'h1C, rv); check("R12 rx flushed", rv, 32'd0);
    wr(6'h00, 32'h77);
    rd(6'h18, rv); check("R12 cmd write ignored", rv, 32'd0);
    pushRx(8'h33);
    rd(6'h1C, rv); check("R12 rx push ignored", rv, 32'd0);
    rd(6'h20, rv); check("R12 timing kept", rv, 32'h1234);
    rd(6'h10, rv); check("R12 status kept", rv & 32'h8, 32'h8);
    wr(6'h10, 32'h1F);
    rd(6'h10, rv); check("R12 no set while disabled", rv, 32'd0);
    engBusy = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule